// File: doc/BRIEF.md
# Reference Time Counters

This block keeps two free-running time values derived from a fixed 25 MHz reference clock. The first is a fine-grained cycle count. It moves forward in steps of 16 reference cycles, once every 640 ns, so its lowest four bits always read zero. It returns to zero each time it reaches the number of reference cycles in one second, which is 25,000,000 by default. The second value counts whole seconds since the last cold reset. It advances on the same clock edge on which the cycle count wraps.

Software reads both values through a small register-select read port. Read data is registered and appears one clock after the request. The cycle count is read-only. A write aimed at it changes nothing and raises a one-cycle error flag. Writes to any other select value are dropped silently. All sizes are parameters, so a shorter "second" can be used when a run must be short.

Top module: `ref_time_counters`

## Requirements
- R1: While reset is high and on the first clock after it, both counters are zero, `rd_data` is zero and `wr_err` is low.
- R2: The cycle count rises by exactly 16 on every 16th clock edge after reset and holds its value on all other edges. After n edges it equals floor(n/16)*16, taken modulo the wrap value.
- R3: The four least significant bits of the cycle count always read zero.
- R4: When the next step would reach `WRAP_COUNT` (25,000,000 by default), the cycle count becomes zero instead. It never reads a value at or above `WRAP_COUNT`.
- R5: The seconds count increments by one on the same edge on which the cycle count wraps to zero, and at no other edge. After n edges it equals floor(n / `WRAP_COUNT`).
- R6: The seconds count is `SEC_W` bits wide (32 by default) and rolls over from all ones to zero with no other effect.
- R7: A read with select 0 returns the cycle count and a read with select 1 returns the seconds count, each zero-extended to `DATA_W` bits. Selects 2 and 3 return zero. The data is the counter value before the edge that takes the request, and it appears on `rd_data` one clock later.
- R8: When `rd_en` is low, `rd_data` keeps its last value.
- R9: A write with select 0 drives `wr_err` high for exactly the one clock that follows the request and leaves the cycle count unchanged.
- R10: A write with select 1, 2 or 3 raises no error and changes neither counter.
- R11: Asserting reset during operation returns both counters to zero, and counting resumes from zero after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz reference clock |
| rst | input | 1 | Synchronous active-high cold reset |
| rd_en | input | 1 | Read request for the selected register |
| wr_en | input | 1 | Write request for the selected register |
| addr | input | 2 | Register select: 0 cycle count, 1 seconds, 2 and 3 unmapped |
| rd_data | output | DATA_W | Registered read data, valid one clock after `rd_en` |
| wr_err | output | 1 | One-clock pulse after a write to the read-only cycle count |

## Verification
Read data and the write-error flag are both registered, so each result is due exactly one clock edge after the edge that takes the request. The counters themselves change only on the edge that closes every 16th cycle, and on wraps. The bench counts the edges since reset was released and notes that count at the falling edge on which it drives a request. It then computes the expected cycle and seconds values from that count and compares them with the outputs at the next falling edge, well away from the active edge. A shortened wrap value, and a narrower seconds counter, let the bench reach several cycle-count wraps and a seconds rollover within the run.

// File: rtl/ref_time_pkg.sv
package ref_time_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CYCLE   = 2'd0,
        SEL_SECONDS = 2'd1,
        SEL_SPARE0  = 2'd2,
        SEL_SPARE1  = 2'd3
    } rt_sel_e;

    typedef struct packed {
        logic    rd;
        logic    wr;
        rt_sel_e sel;
    } rt_req_t;

    function automatic logic f_write_rejected(rt_req_t r);
        return r.wr && (r.sel == SEL_CYCLE);
    endfunction

endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
    parameter int TICK_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] phase;

    assign tick = (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    generate
        if (TICK_DIV > 1) begin : g_spacing
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rt_cycle_counter.sv
module rt_cycle_counter #(
    parameter int TICK_DIV   = 16,
    parameter int WRAP_COUNT = 25_000_000,
    parameter int CYC_W      = $clog2(WRAP_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CYC_W-1:0] count,
    output logic             wrap
);
    localparam logic [CYC_W-1:0] STEP  = CYC_W'(TICK_DIV);
    localparam logic [CYC_W-1:0] LIMIT = CYC_W'(WRAP_COUNT);
    localparam int LOW_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CYC_W-1:0] stepped;

    assign stepped = count + STEP;
    assign wrap    = tick && (stepped >= LIMIT);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (wrap) count <= '0;
        else if (tick) count <= stepped;
    end

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    // R4
    below_limit_chk: assert property (@(posedge clk) disable iff (rst)
        count < LIMIT);

    // R3
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        count[LOW_W-1:0] == '0);

endmodule

// File: rtl/rt_seconds_counter.sv
module rt_seconds_counter #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [SEC_W-1:0] seconds
);
    always_ff @(posedge clk) begin
        if (rst)          seconds <= '0;
        else if (advance) seconds <= seconds + 1'b1;
    end

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(seconds));

endmodule

// File: rtl/ref_time_counters.sv
module ref_time_counters
    import ref_time_pkg::*;
#(
    parameter int TICK_DIV   = 16,
    parameter int WRAP_COUNT = 25_000_000,
    parameter int SEC_W      = 32,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_err
);
    localparam int CYC_W = $clog2(WRAP_COUNT + 1);

    rt_req_t           req;
    logic              tick;
    logic              wrap;
    logic [CYC_W-1:0]  cyc_val;
    logic [SEC_W-1:0]  sec_val;
    logic [DATA_W-1:0] read_mux;

    assign req.rd  = rd_en;
    assign req.wr  = wr_en;
    assign req.sel = rt_sel_e'(addr);

    rt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rt_cycle_counter #(
        .TICK_DIV   (TICK_DIV),
        .WRAP_COUNT (WRAP_COUNT),
        .CYC_W      (CYC_W)
    ) u_cyc (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .count (cyc_val),
        .wrap  (wrap)
    );

    rt_seconds_counter #(.SEC_W(SEC_W)) u_sec (
        .clk     (clk),
        .rst     (rst),
        .advance (wrap),
        .seconds (sec_val)
    );

    always_comb begin
        unique case (req.sel)
            SEL_CYCLE:   read_mux = DATA_W'(cyc_val);
            SEL_SECONDS: read_mux = DATA_W'(sec_val);
            default:     read_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            wr_err  <= 1'b0;
        end else begin
            if (req.rd) rd_data <= read_mux;
            wr_err <= f_write_rejected(req);
        end
    end

    // R5
    sec_follows_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_val == '0 && $past(cyc_val) != '0) |-> (sec_val == $past(sec_val) + 1'b1));

    // R9
    err_on_cycle_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0) |=> wr_err);

    // R10
    no_err_elsewhere_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 2'd0) |=> !wr_err);

    // R8
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/ref_time_counters_tb.sv
module ref_time_counters_tb;

    localparam int CLK_PERIOD = 40;
    localparam int TICK       = 16;
    localparam int WRAP       = 320;
    localparam int SECW       = 4;
    localparam int DW         = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] rd_data;
    logic          wr_err;

    int n_edges = 0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    ref_time_counters #(
        .TICK_DIV   (TICK),
        .WRAP_COUNT (WRAP),
        .SEC_W      (SECW),
        .DATA_W     (DW)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .rd_data (rd_data),
        .wr_err  (wr_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) n_edges <= 0;
        else     n_edges <= n_edges + 1;
    end

    function automatic int exp_cycle(int n);
        return ((n / TICK) * TICK) % WRAP;
    endfunction

    function automatic int exp_secs(int n);
        return (n / WRAP) % (1 << SECW);
    endfunction

    function automatic int exp_read(int n, int a);
        if (a == 0) return exp_cycle(n);
        if (a == 1) return exp_secs(n);
        return 0;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    task automatic do_read(int a, string tag);
        int k;
        k = n_edges;
        addr  = a[1:0];
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rd_data, DW'(exp_read(k, a)));
    endtask

    task automatic do_write(int a, string tag);
        addr  = a[1:0];
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(tag, {31'd0, wr_err}, DW'(a == 0));
        @(negedge clk);
        check(tag, {31'd0, wr_err}, 32'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        int v;
        logic [DW-1:0] held;
        seed = $urandom(32'h5eed_1234);
        @(negedge clk);
        check("R1 rd_data in reset", rd_data, 0);
        check("R1 wr_err in reset", {31'd0, wr_err}, 0);
        idle(2);
        rst = 1'b0;
        do_read(0, "R1 cycle after reset");
        do_read(1, "R1 seconds after reset");

        // R2 / R3 stepping around a tick boundary
        idle(12);
        for (int i = 0; i < 40; i++) do_read(0, "R2 R3 cycle step");

        // R4 / R5 across a wrap
        while ((n_edges % WRAP) != WRAP - 3) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            do_read(i % 2, "R4 R5 around wrap");
        end

        // R7 unmapped selects and R8 hold
        do_read(2, "R7 select 2 reads zero");
        do_read(3, "R7 select 3 reads zero");
        do_read(1, "R7 seconds read");
        held = rd_data;
        idle(37);
        check("R8 rd_data held", rd_data, held);

        // R9 / R10 writes
        do_write(0, "R9 write cycle err");
        do_read(0, "R9 cycle unchanged by write");
        for (int a = 1; a < 4; a++) do_write(a, "R10 write no err");
        do_read(1, "R10 seconds unchanged by write");
        do_read(0, "R10 cycle unchanged by write");

        // R6 seconds rollover
        while (n_edges < (1 << SECW) * WRAP + 5) @(negedge clk);
        do_read(1, "R6 seconds rolled over");
        do_read(0, "R6 cycle after rollover");

        // random mix
        for (int i = 0; i < 250; i++) begin
            idle($urandom % 40);
            v = $urandom % 8;
            if (v == 7) do_write($urandom % 4, "R9 R10 random write");
            else        do_read($urandom % 4, "R7 random read");
        end

        // R11 reset mid-run
        do_reset();
        do_read(0, "R11 cycle after mid reset");
        do_read(1, "R11 seconds after mid reset");
        idle(WRAP + 7);
        do_read(1, "R11 seconds resumes");
        do_read(0, "R11 cycle resumes");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule